// File: doc/BRIEF.md
# PHY Register Access Bus Controller

This block is a bus master that reads and writes registers in an external PHY device. It uses a parallel address and data bus. A single command port accepts an address, write data and a read/write flag, together with a start pulse. The controller then runs one access on the external pins. When the access ends it returns a one-cycle done pulse. For reads, the captured data is returned in the same cycle as that pulse.

Mode inputs are sampled when an access starts and control how the access runs:
- **Completion mode.** The access either lasts a fixed 200 ns window, counted in clocks, or waits for an acknowledge from the PHY. The acknowledge wait is guarded by a timeout.
- **Data width.** The bus is 8 or 16 bits wide. In 16-bit mode the upper byte travels on its own group of eight pins.
- **Parity.** Each byte lane in use carries an odd-parity bit. Read data is checked against it, and a failure sets a sticky status bit when checking is enabled.
- **Debug.** A debug input keeps the address pins undriven.

Top module: `phy_reg_bus_ctrl`

## Requirements
- R1: After reset the chip select, read strobe and write strobe are high (inactive), all output enables are low, and done, timeout and the parity-error status are 0. The read strobe and write strobe are never low together.
- R2: With the acknowledge mode input at 0 when an access starts, chip select stays low for exactly FIXED_CYC clocks, computed as ceil(WINDOW_PS / CLK_PERIOD_PS). This is 40 clocks at the defaults. The done pulse follows in the next cycle.
- R3: With the acknowledge mode input at 1, the access ends at the first clock edge on which the acknowledge input is high. Chip select then rises and done pulses in the cycle after that edge.
- R4: In acknowledge mode, if no acknowledge arrives within ACK_TIMEOUT clocks (64 at the defaults), the access ends with done and the timeout flag both high and read data of 0.
- R5: Done is high for exactly one clock per access. Read data is valid while done is high.
- R6: A write in 16-bit mode drives bits 7..0 on the low lane and bits 15..8 on the high lane, with both lane enables high. A write in 8-bit mode leaves the high-lane enable low.
- R7: A read in 8-bit mode returns the low-lane byte in bits 7..0 and 0 in bits 15..8. A read in 16-bit mode returns the high lane in bits 15..8.
- R8: On writes, parity bit 0 is odd parity over the low lane: the bit is the XNOR of the byte's bits. Parity bit 1 is the same function over the high lane.
- R9: When parity checking is enabled, a read whose lane in use fails odd parity (byte plus its parity bit has an even number of ones) sets the parity-error status. It is set in the same cycle as done. A lane not in use is not checked. The status stays set over later accesses.
- R10: When parity checking is disabled, a read with bad parity leaves the parity-error status at 0.
- R11: A one-cycle pulse on the clear input resets the parity-error status to 0.
- R12: During an access the address output enable is high, unless the debug address-disable input is high, in which case it stays low.
- R13: A start pulse that arrives while an access is in progress is ignored: it produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start an access (taken only when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_done | output | 1 | One-cycle end-of-access pulse |
| cmd_rdata | output | 16 | Read data, valid with done |
| cmd_timeout | output | 1 | Acknowledge timeout, pulses with done |
| mode_ack | input | 1 | 0 = fixed window, 1 = acknowledge terminated |
| mode_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| par_check_en | input | 1 | Enable read parity checking |
| addr_drive_off | input | 1 | Debug: do not drive address pins |
| par_err_clr | input | 1 | Clear parity-error status |
| par_err | output | 1 | Sticky parity-error status |
| phy_addr | output | ADDR_W | Address pins |
| phy_addr_oe | output | 1 | Address pin enable |
| phy_cs_n | output | 1 | Chip select, active low |
| phy_rd_n | output | 1 | Read strobe, active low |
| phy_wr_n | output | 1 | Write strobe, active low |
| phy_dlo_out | output | 8 | Low data lane out |
| phy_dlo_oe | output | 1 | Low lane enable |
| phy_dlo_in | input | 8 | Low data lane in |
| phy_dhi_out | output | 8 | High data lane out |
| phy_dhi_oe | output | 1 | High lane enable |
| phy_dhi_in | input | 8 | High data lane in |
| phy_par_out | output | 2 | Parity out, bit 0 low lane, bit 1 high lane |
| phy_par_in | input | 2 | Parity in, bit 0 low lane, bit 1 high lane |
| phy_ack | input | 1 | Acknowledge from the PHY |

## Verification
The bench counts the exact number of clocks chip select stays low in both completion modes. An off-by-one window counter would show up as 39 or 41 cycles instead of 40, and a late acknowledge sample would show up as one extra cycle.

It also targets three read-path faults:
- **Timeout path.** A stuck controller would never signal done, and a wrong timeout path would return stale data.
- **Lane faults.** A controller that ignored the width mode would leak the high byte into 8-bit reads.
- **Parity scope.** A controller that checked parity on the unused upper lane would flag a false error.

Parity status is checked for sticky behaviour, for no change when checking is disabled, and for clearing. A start pulse issued mid-access must not produce a second done pulse.

// File: rtl/phy_reg_bus_ctrl.sv
module phy_reg_bus_ctrl #(
  parameter int ADDR_W        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int WINDOW_PS     = 200000,
  parameter int ACK_TIMEOUT   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_wdata,
  output logic              cmd_done,
  output logic [15:0]       cmd_rdata,
  output logic              cmd_timeout,
  input  logic              mode_ack,
  input  logic              mode_wide,
  input  logic              par_check_en,
  input  logic              addr_drive_off,
  input  logic              par_err_clr,
  output logic              par_err,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              phy_addr_oe,
  output logic              phy_cs_n,
  output logic              phy_rd_n,
  output logic              phy_wr_n,
  output logic [7:0]        phy_dlo_out,
  output logic              phy_dlo_oe,
  input  logic [7:0]        phy_dlo_in,
  output logic [7:0]        phy_dhi_out,
  output logic              phy_dhi_oe,
  input  logic [7:0]        phy_dhi_in,
  output logic [1:0]        phy_par_out,
  input  logic [1:0]        phy_par_in,
  input  logic              phy_ack
);
  localparam int FIXED_CYC = (WINDOW_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MAX_CYC   = (FIXED_CYC > ACK_TIMEOUT) ? FIXED_CYC : ACK_TIMEOUT;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FIX_LAST = CNT_W'(FIXED_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(ACK_TIMEOUT - 1);

  logic              busy;
  logic              wr_q, ack_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic [CNT_W-1:0]  cnt;

  wire fixed_end = !ack_q && (cnt == FIX_LAST);
  wire ack_end   = ack_q && phy_ack;
  wire to_end    = ack_q && !phy_ack && (cnt == TO_LAST);
  wire acc_end   = busy && (fixed_end || ack_end || to_end);

  wire lo_bad  = ~^{phy_par_in[0], phy_dlo_in};
  wire hi_bad  = ~^{phy_par_in[1], phy_dhi_in};
  wire par_bad = lo_bad || (wide_q && hi_bad);
  wire [15:0] rd_sample = {wide_q ? phy_dhi_in : 8'h00, phy_dlo_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt     <= '0;
    end else if (!busy) begin
      cnt <= '0;
      if (cmd_start) begin
        busy    <= 1'b1;
        wr_q    <= cmd_write;
        ack_q   <= mode_ack;
        wide_q  <= mode_wide;
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
      end
    end else if (acc_end) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done    <= 1'b0;
      cmd_timeout <= 1'b0;
      cmd_rdata   <= '0;
    end else begin
      cmd_done    <= acc_end;
      cmd_timeout <= acc_end && to_end;
      if (acc_end)
        cmd_rdata <= (to_end || wr_q) ? 16'h0000 : rd_sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      par_err <= 1'b0;
    else if (acc_end && !to_end && !wr_q && par_check_en && par_bad)
      par_err <= 1'b1;
    else if (par_err_clr)
      par_err <= 1'b0;
  end

  assign phy_addr    = addr_q;
  assign phy_addr_oe = busy && !addr_drive_off;
  assign phy_cs_n    = !busy;
  assign phy_rd_n    = !(busy && !wr_q);
  assign phy_wr_n    = !(busy && wr_q);
  assign phy_dlo_out = wdata_q[7:0];
  assign phy_dhi_out = wdata_q[15:8];
  assign phy_dlo_oe  = busy && wr_q;
  assign phy_dhi_oe  = busy && wr_q && wide_q;
  assign phy_par_out = {~^wdata_q[15:8], ~^wdata_q[7:0]};
endmodule

// File: rtl/phy_reg_bus_ctrl_chk.sv
module phy_reg_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_done,
  input logic cmd_timeout,
  input logic par_err,
  input logic phy_cs_n,
  input logic phy_rd_n,
  input logic phy_wr_n,
  input logic phy_dlo_oe,
  input logic phy_dhi_oe
);
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!phy_rd_n && !phy_wr_n));

  p_done_after_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_cs_n ##1 cmd_done |-> phy_cs_n);

  p_timeout_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_timeout |-> cmd_done);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  p_lane_oe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_dlo_oe || phy_dhi_oe) |-> (!phy_wr_n && !phy_cs_n));

  p_perr_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> cmd_done);
endmodule

bind phy_reg_bus_ctrl phy_reg_bus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_timeout(cmd_timeout),
  .par_err(par_err), .phy_cs_n(phy_cs_n), .phy_rd_n(phy_rd_n),
  .phy_wr_n(phy_wr_n), .phy_dlo_oe(phy_dlo_oe), .phy_dhi_oe(phy_dhi_oe)
);

// File: tb/test_phy_reg_bus_ctrl.sv
module test_phy_reg_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 0, cmd_write = 0;
  logic [7:0]  cmd_addr = 0;
  logic [15:0] cmd_wdata = 0;
  logic        cmd_done, cmd_timeout, par_err;
  logic [15:0] cmd_rdata;
  logic        mode_ack = 0, mode_wide = 0, par_check_en = 0;
  logic        addr_drive_off = 0, par_err_clr = 0;
  logic [7:0]  phy_addr, phy_dlo_out, phy_dhi_out;
  logic        phy_addr_oe, phy_cs_n, phy_rd_n, phy_wr_n, phy_dlo_oe, phy_dhi_oe;
  logic [1:0]  phy_par_out;
  logic [7:0]  phy_dlo_in = 0, phy_dhi_in = 0;
  logic [1:0]  phy_par_in = 0;
  logic        phy_ack = 0;

  int n_checks = 0, n_fail = 0;
  int r_cyc, r_dones;
  logic [15:0] r_rdata;
  logic r_to, r_aoe, r_dlo_oe, r_dhi_oe;
  logic [7:0] r_dlo, r_dhi, r_addr;
  logic [1:0] r_par;

  always #2.5 clk = ~clk;

  phy_reg_bus_ctrl i_phy_reg_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata), .cmd_timeout(cmd_timeout), .mode_ack(mode_ack),
    .mode_wide(mode_wide), .par_check_en(par_check_en),
    .addr_drive_off(addr_drive_off), .par_err_clr(par_err_clr), .par_err(par_err),
    .phy_addr(phy_addr), .phy_addr_oe(phy_addr_oe), .phy_cs_n(phy_cs_n),
    .phy_rd_n(phy_rd_n), .phy_wr_n(phy_wr_n), .phy_dlo_out(phy_dlo_out),
    .phy_dlo_oe(phy_dlo_oe), .phy_dlo_in(phy_dlo_in), .phy_dhi_out(phy_dhi_out),
    .phy_dhi_oe(phy_dhi_oe), .phy_dhi_in(phy_dhi_in), .phy_par_out(phy_par_out),
    .phy_par_in(phy_par_in), .phy_ack(phy_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_access(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                            input int ack_at, input bit extra_start);
    @(negedge clk);
    cmd_write = wr; cmd_addr = a; cmd_wdata = wd; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0; r_cyc = 0;
    while (!cmd_done && r_cyc < 1000) begin
      if (!phy_cs_n) begin
        r_cyc++;
        if (r_cyc == 1) begin
          r_aoe = phy_addr_oe; r_addr = phy_addr; r_dlo = phy_dlo_out; r_dhi = phy_dhi_out;
          r_dlo_oe = phy_dlo_oe; r_dhi_oe = phy_dhi_oe; r_par = phy_par_out;
        end
      end
      phy_ack = (ack_at > 0 && r_cyc == ack_at);
      cmd_start = (extra_start && r_cyc == 3);
      @(negedge clk);
    end
    phy_ack = 0; cmd_start = 0;
    r_rdata = cmd_rdata; r_to = cmd_timeout;
    @(negedge clk);
    r_dones = 0;
    for (int i = 0; i < 60; i++) begin
      if (cmd_done) r_dones++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(phy_cs_n && phy_rd_n && phy_wr_n, "R1 strobes idle", {phy_cs_n, phy_rd_n, phy_wr_n}, 3'b111);
    chk(!phy_addr_oe && !phy_dlo_oe && !phy_dhi_oe, "R1 enables low",
        {phy_addr_oe, phy_dlo_oe, phy_dhi_oe}, 0);
    chk(!cmd_done && !cmd_timeout && !par_err, "R1 flags low", {cmd_done, cmd_timeout, par_err}, 0);
  endtask

  task automatic t_fixed_wide_write;
    mode_ack = 0; mode_wide = 1;
    run_access(1, 8'h3C, 16'hA51F, 0, 0);
    chk(r_cyc == 40, "R2 fixed window length", r_cyc, 40);
    chk(r_dlo == 8'h1F && r_dhi == 8'hA5, "R6 wide lanes", {r_dhi, r_dlo}, 16'hA51F);
    chk(r_dlo_oe && r_dhi_oe, "R6 wide enables", {r_dlo_oe, r_dhi_oe}, 2'b11);
    chk(r_par == {~^8'hA5, ~^8'h1F}, "R8 odd parity out", r_par, {~^8'hA5, ~^8'h1F});
    chk(r_aoe && r_addr == 8'h3C, "R12 address driven", {r_aoe, r_addr}, {1'b1, 8'h3C});
    chk(r_dones == 0, "R5 single done", r_dones, 0);
  endtask

  task automatic t_narrow_write;
    mode_ack = 0; mode_wide = 0;
    run_access(1, 8'h05, 16'hFF70, 0, 0);
    chk(r_dlo == 8'h70 && r_dlo_oe && !r_dhi_oe, "R6 narrow lanes", {r_dhi_oe, r_dlo_oe, r_dlo}, {2'b01, 8'h70});
    chk(r_par[0] == ~^8'h70, "R8 low lane parity", r_par[0], ~^8'h70);
  endtask

  task automatic t_ack_read_wide;
    mode_ack = 1; mode_wide = 1; par_check_en = 1;
    phy_dlo_in = 8'h34; phy_dhi_in = 8'h12;
    phy_par_in = {~^8'h12, ~^8'h34};
    run_access(0, 8'h10, 0, 7, 0);
    chk(r_cyc == 7, "R3 ack terminates", r_cyc, 7);
    chk(r_rdata == 16'h1234 && !r_to, "R7 wide read data", r_rdata, 16'h1234);
    chk(!par_err, "R9 good parity no error", par_err, 0);
  endtask

  task automatic t_timeout;
    mode_ack = 1; phy_dlo_in = 8'h77;
    run_access(0, 8'h11, 0, 0, 0);
    chk(r_cyc == 64, "R4 timeout length", r_cyc, 64);
    chk(r_to && r_rdata == 0, "R4 timeout flag and data", {r_to, r_rdata}, {1'b1, 16'h0});
  endtask

  task automatic t_narrow_read;
    mode_ack = 0; mode_wide = 0; par_check_en = 1;
    phy_dlo_in = 8'hC3; phy_dhi_in = 8'hAA;
    phy_par_in = {~~^8'hAA, ~^8'hC3};
    run_access(0, 8'h20, 0, 0, 0);
    chk(r_rdata == 16'h00C3, "R7 narrow read zero upper", r_rdata, 16'h00C3);
    chk(!par_err, "R9 unused lane not checked", par_err, 0);
  endtask

  task automatic t_parity_disabled;
    mode_ack = 0; mode_wide = 1; par_check_en = 0;
    phy_dlo_in = 8'h01; phy_par_in = 2'b11;
    run_access(0, 8'h21, 0, 0, 0);
    chk(!par_err, "R10 disabled no error", par_err, 0);
  endtask

  task automatic t_parity_err_sticky;
    mode_ack = 0; mode_wide = 1; par_check_en = 1;
    phy_dlo_in = 8'h01; phy_dhi_in = 8'h00; phy_par_in = 2'b11;
    run_access(0, 8'h22, 0, 0, 0);
    chk(par_err, "R9 error set", par_err, 1);
    phy_par_in = {~^8'h00, ~^8'h01};
    run_access(0, 8'h23, 0, 0, 0);
    chk(par_err, "R9 error sticky", par_err, 1);
    @(negedge clk); par_err_clr = 1;
    @(negedge clk); par_err_clr = 0;
    chk(!par_err, "R11 clear", par_err, 0);
  endtask

  task automatic t_addr_off;
    addr_drive_off = 1; mode_ack = 0;
    run_access(1, 8'h44, 16'h0001, 0, 0);
    chk(!r_aoe, "R12 address drive disabled", r_aoe, 0);
    addr_drive_off = 0;
  endtask

  task automatic t_busy_start;
    mode_ack = 0;
    run_access(1, 8'h50, 16'h0002, 0, 1);
    chk(r_cyc == 40 && r_dones == 0, "R13 start while busy ignored", {r_cyc[15:0], r_dones[15:0]}, {16'd40, 16'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fixed_wide_write();
    t_narrow_write();
    t_ack_read_wide();
    t_timeout();
    t_narrow_read();
    t_parity_disabled();
    t_parity_err_sticky();
    t_addr_off();
    t_busy_start();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule